// File: doc/BRIEF.md
# Multiword ADC Read Controller

A host-side sequencer for an 18-bit successive-approximation converter that has a parallel output port. The converter can present its result whole or in pieces selected by two format inputs. The controller owns every control line of that port: an active-low convert-start, chip select and read strobe, plus a byte-fold select and a bus-size select. It samples the converter's BUSY output and its 18-bit data pins.

Out of reset, the controller issues the start-up read strobes the converter needs. After that it waits for a request, which comes either from a one-cycle start pulse or from a periodic tick. For each request it drops convert-start, waits for BUSY to fall, and then runs one, two or three read strobes. The number of strobes depends on the host bus width chosen by `mode_i`. The partial words are merged into one 18-bit straight-binary sample, which is presented with a one-cycle done strobe.

All analog timing rules are expressed as whole clock cycles through parameters:
- the convert-start pulse width;
- the select-to-read setup time;
- the read-low and read-high durations;
- the quiet window before and after each convert-start falling edge, during which no read strobe and no select change is allowed.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, `busy_o` is high and exactly INIT_READS (3) read strobes are issued with `cs_n_o` low before the first convert-start falling edge. `busy_o` then drops.
- R2: When `convst_n_o` falls, `cs_n_o` is already low from the previous cycle. `convst_n_o` stays low for exactly CONV_LOW cycles.
- R3: Read strobes of a conversion are issued only after `busy_adc_i` has been seen falling after that conversion's convert-start.
- R4: With `mode_i`=0 (18-bit; value 3 behaves the same), one read is made with (`byte_sel_o`,`bus_sel_o`)=(0,0), and the sample is `data_i[17:0]`. `skip_last_i` has no effect in this mode.
- R5: With `mode_i`=1 (16-bit), two reads are made. The first, with selects (0,0), supplies sample bits 17..2 from `data_i[17:2]`. The second, with selects (0,1), supplies bits 1..0 from `data_i[3:2]`.
- R6: With `mode_i`=2 (8-bit), three reads are made, all taken from `data_i[17:10]`, with selects (0,0), (1,0) and (1,1). They supply sample bits 17..10, 9..2 and 1..0; the last read uses `data_i[11:10]`.
- R7: With `skip_last_i`=1 in 16-bit or 8-bit mode, the final read is left out and sample bits 1..0 are zero.
- R8: No read strobe and no select change occurs in the PRE_QUIET cycles before a convert-start falling edge. The same holds for the POST_QUIET cycles counted from that edge.
- R9: Selects are stable for at least SETUP_CYC cycles before a read strobe falls and stay stable while it is low. The data is captured in the last of the RD_LOW read-low cycles.
- R10: A request that arrives while the controller is idle but inside the pre-convert quiet window is held, and it starts a conversion once the window has passed.
- R11: `done_o` is high for exactly one cycle per conversion. `sample_o` carries the new sample from that cycle and holds it until the next done.
- R12: Requests that arrive while `busy_o` is high are dropped and start no conversion.
- R13: A pulse on `tick_i` starts a conversion exactly like `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Host bus width: 0 = 18-bit, 1 = 16-bit, 2 = 8-bit |
| skip_last_i | input | 1 | Omit the final read in 16-bit and 8-bit modes |
| start_i | input | 1 | Conversion request pulse |
| tick_i | input | 1 | Periodic conversion request |
| busy_adc_i | input | 1 | Converter BUSY, high while converting |
| data_i | input | 18 | Converter data pins |
| convst_n_o | output | 1 | Convert-start, active low |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| byte_sel_o | output | 1 | Byte-fold select |
| bus_sel_o | output | 1 | Bus-size select |
| sample_o | output | 18 | Assembled sample |
| done_o | output | 1 | One-cycle pulse when a sample is ready |
| busy_o | output | 1 | High while start-up reads or a conversion sequence are active |

## Verification
The converter model in the bench drives a junk pattern on the data pins during the first read-low cycle. A controller that samples early therefore returns a visibly wrong sample. The model fills unused pins with ones, so a controller that takes the wrong pin field in a fold mode also returns a wrong sample.

Conversions with a one-cycle BUSY pulse make the post-convert quiet window the binding constraint, so a controller that reads as soon as BUSY drops would break the window. Requests are issued right after each done pulse and again in the middle of a conversion. A design that lost held requests, or queued requests it should drop, would show a missing or an extra convert-start.

The bench checks the select sequence at every read strobe against the mode, which catches swapped or missing fold steps.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int unsigned WORD_W = 18;

  localparam logic [1:0] MODE_W18 = 2'd0;
  localparam logic [1:0] MODE_W16 = 2'd1;
  localparam logic [1:0] MODE_W8  = 2'd2;

  typedef enum logic [2:0] {
    ST_BOOT, ST_IDLE, ST_CONV_CS, ST_CONV_LO, ST_WAIT, ST_SETUP, ST_RD_LO, ST_RD_HI
  } state_e;

  // {byte_sel, bus_sel} for read slot idx
  function automatic logic [1:0] read_sel(input logic [1:0] mode, input logic [1:0] idx);
    if (mode == MODE_W16) return (idx == 2'd1) ? 2'b01 : 2'b00;
    if (mode == MODE_W8) begin
      if (idx == 2'd0) return 2'b00;
      if (idx == 2'd1) return 2'b10;
      return 2'b11;
    end
    return 2'b00;
  endfunction
endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/adc_rd_assemble.sv
module adc_rd_assemble import adc_rd_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        idx_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
    end else if (cap_i) begin
      if (mode_i == MODE_W16) begin
        if (idx_i == 2'd0) word_q <= {data_i[17:2], 2'b00};
        else               word_q[1:0] <= data_i[3:2];
      end else if (mode_i == MODE_W8) begin
        if (idx_i == 2'd0)      word_q <= {data_i[17:10], 10'd0};
        else if (idx_i == 2'd1) word_q[9:2] <= data_i[17:10];
        else                    word_q[1:0] <= data_i[11:10];
      end else begin
        word_q <= data_i;
      end
    end
  end

  assign word_o = word_q;

  AST_W18_ONE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && (mode_i == MODE_W18 || mode_i == 2'd3)) |-> (idx_i == 2'd0)); // R4
  AST_W16_TWO_SLOTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && mode_i == MODE_W16) |-> (idx_i <= 2'd1)); // R5
  AST_W8_THREE_SLOTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && mode_i == MODE_W8) |-> (idx_i <= 2'd2)); // R6
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl import adc_rd_pkg::*; #(
  parameter int unsigned CONV_LOW   = 4,
  parameter int unsigned PRE_QUIET  = 13,
  parameter int unsigned POST_QUIET = 4,
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned RD_LOW     = 3,
  parameter int unsigned RD_HIGH    = 2,
  parameter int unsigned INIT_READS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              skip_last_i,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic              busy_adc_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              convst_n_o,
  output logic              cs_n_o,
  output logic              rd_n_o,
  output logic              byte_sel_o,
  output logic              bus_sel_o,
  output logic [WORD_W-1:0] sample_o,
  output logic              done_o,
  output logic              busy_o
);
  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  localparam int unsigned T_MAX = max2(max2(CONV_LOW, POST_QUIET), max2(max2(SETUP_CYC, RD_LOW), RD_HIGH));
  localparam int unsigned TW    = $clog2(T_MAX + 1);
  localparam int unsigned QW    = $clog2(PRE_QUIET + 1);
  localparam int unsigned IW    = $clog2(max2(INIT_READS, 3));

  state_e            state_q, state_d;
  logic [IW-1:0]     idx_q, last_idx;
  logic [1:0]        mode_q, sel_cur, sel_prev_q, nrd;
  logic [QW-1:0]     qcnt_q, qcnt_d;
  logic [TW-1:0]     ph_val;
  logic [WORD_W-1:0] word, sample_q;
  logic init_q, pend_q, fall_q, busy_q, done_q, skip_q;
  logic req, act, go, ph_load, ph_zero, post_zero, cap, seq_end;

  assign req = start_i | tick_i;

  always_comb begin
    sel_cur = 2'b00;
    if (!init_q && state_q inside {ST_SETUP, ST_RD_LO, ST_RD_HI})
      sel_cur = read_sel(mode_q, idx_q[1:0]);
  end

  // quiet-run tracking for the convert-start blackout
  assign act    = (state_q == ST_RD_LO) || (sel_cur != sel_prev_q);
  assign qcnt_d = act ? '0 : ((qcnt_q == QW'(PRE_QUIET)) ? qcnt_q : qcnt_q + 1'b1);
  assign go     = (pend_q || req) && (qcnt_d >= QW'(PRE_QUIET - 1));

  always_comb begin
    unique case (mode_q)
      MODE_W16: nrd = skip_q ? 2'd1 : 2'd2;
      MODE_W8:  nrd = skip_q ? 2'd2 : 2'd3;
      default:  nrd = 2'd1;
    endcase
  end

  assign last_idx = init_q ? IW'(INIT_READS - 1) : IW'(nrd - 2'd1);
  assign seq_end  = (state_q == ST_RD_HI) && ph_zero && (idx_q == last_idx);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_BOOT:    state_d = ST_SETUP;
      ST_IDLE:    if (go) state_d = ST_CONV_CS;
      ST_CONV_CS: state_d = ST_CONV_LO;
      ST_CONV_LO: if (ph_zero) state_d = ST_WAIT;
      ST_WAIT:    if (fall_q && post_zero) state_d = ST_SETUP;
      ST_SETUP:   if (ph_zero) state_d = ST_RD_LO;
      ST_RD_LO:   if (ph_zero) state_d = ST_RD_HI;
      ST_RD_HI:   if (ph_zero) state_d = seq_end ? ST_IDLE : ST_SETUP;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign ph_load = (state_d != state_q);
  always_comb begin
    unique case (state_d)
      ST_CONV_LO: ph_val = TW'(CONV_LOW - 1);
      ST_SETUP:   ph_val = TW'(SETUP_CYC - 1);
      ST_RD_LO:   ph_val = TW'(RD_LOW - 1);
      ST_RD_HI:   ph_val = TW'(RD_HIGH - 1);
      default:    ph_val = '0;
    endcase
  end

  adc_rd_timer #(.CW(TW)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ph_load), .val_i(ph_val), .zero_o(ph_zero)
  );

  adc_rd_timer #(.CW(TW)) u_post (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(state_q == ST_CONV_CS),
    .val_i(TW'(POST_QUIET)), .zero_o(post_zero)
  );

  assign cap = (state_q == ST_RD_LO) && ph_zero && !init_q;

  adc_rd_assemble u_asm (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap), .mode_i(mode_q),
    .idx_i(idx_q[1:0]), .data_i(data_i), .word_o(word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_BOOT;
      idx_q      <= '0;
      init_q     <= 1'b1;
      pend_q     <= 1'b0;
      fall_q     <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      mode_q     <= MODE_W18;
      skip_q     <= 1'b0;
      sel_prev_q <= 2'b00;
      qcnt_q     <= '0;
      sample_q   <= '0;
    end else begin
      state_q    <= state_d;
      busy_q     <= busy_adc_i;
      sel_prev_q <= sel_cur;
      qcnt_q     <= qcnt_d;
      pend_q     <= (state_q == ST_IDLE) && !go && (pend_q || req);
      if (state_q == ST_CONV_CS)
        fall_q <= 1'b0;
      else if (state_q inside {ST_CONV_LO, ST_WAIT} && busy_q && !busy_adc_i)
        fall_q <= 1'b1;
      if (state_q == ST_IDLE && go) begin
        mode_q <= mode_i;
        skip_q <= skip_last_i;
      end
      if (state_q == ST_RD_HI && ph_zero) begin
        if (seq_end) begin
          idx_q  <= '0;
          init_q <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
      done_q <= seq_end && !init_q;
      if (seq_end && !init_q) sample_q <= word;
    end
  end

  assign convst_n_o = (state_q != ST_CONV_LO);
  assign cs_n_o     = (state_q inside {ST_BOOT, ST_IDLE});
  assign rd_n_o     = (state_q != ST_RD_LO);
  assign byte_sel_o = sel_cur[1];
  assign bus_sel_o  = sel_cur[0];
  assign sample_o   = sample_q;
  assign done_o     = done_q;
  assign busy_o     = (state_q != ST_IDLE);

  AST_CS_BEFORE_CONVST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(convst_n_o) |-> $past(!cs_n_o)); // R2
  AST_CS_DURING_CONVST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !convst_n_o |-> !cs_n_o); // R2
  AST_NO_READ_IN_CONVST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !convst_n_o |-> rd_n_o); // R8
  AST_SEL_HOLD_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o && $past(!rd_n_o)) |-> $stable({byte_sel_o, bus_sel_o})); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_READ_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> busy_o); // R12
endmodule

// File: tb/adc_rd_ctrl_tb_top.sv
module adc_rd_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CONV_LOW = 4, PRE_QUIET = 13, POST_QUIET = 4, SETUP_CYC = 1, RD_LOW = 3;

  typedef struct packed {
    logic [1:0]  mode;
    logic        skip;
    logic [7:0]  conv;
    logic [17:0] word;
    logic [17:0] expv;
    logic [1:0]  nrd;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b0, 8'd20, 18'h3FFFF, 18'h3FFFF, 2'd1},
    '{2'd0, 1'b1, 8'd20, 18'h00000, 18'h00000, 2'd1},
    '{2'd1, 1'b0, 8'd20, 18'h2A5C3, 18'h2A5C3, 2'd2},
    '{2'd1, 1'b1, 8'd20, 18'h2A5C3, 18'h2A5C0, 2'd1},
    '{2'd2, 1'b0, 8'd20, 18'h1B7E6, 18'h1B7E6, 2'd3},
    '{2'd2, 1'b1, 8'd20, 18'h1B7E7, 18'h1B7E4, 2'd2},
    '{2'd2, 1'b0, 8'd1,  18'h20001, 18'h20001, 2'd3},
    '{2'd1, 1'b0, 8'd1,  18'h1FFFF, 18'h1FFFF, 2'd2},
    '{2'd0, 1'b1, 8'd1,  18'h15555, 18'h15555, 2'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic skip = 1'b0, start = 1'b0, tick = 1'b0, busy_adc = 1'b0;
  logic [17:0] data = 18'h3FFFF;
  logic convst_n, cs_n, rd_n, byte_sel, bus_sel, done, busy;
  logic [17:0] sample;

  int checks = 0, fails = 0, cyc = 0;
  // monitor / model state
  int quiet_run = 0, post_run = 0, sel_age = 0, conv_low_run = 0, rd_lo_cnt = 0, bcnt = 0;
  int rd_total = 0, convst_falls = 0, reads_seen = 0, rd_idx = 0;
  bit post_open = 0, conv_open = 0;
  logic prev_rd = 1'b1, prev_conv = 1'b1;
  logic [1:0] prev_sel = 2'b00;
  logic [7:0] conv_cyc = 8'd20;
  logic [17:0] adc_word = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_rd_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .skip_last_i(skip), .start_i(start),
    .tick_i(tick), .busy_adc_i(busy_adc), .data_i(data), .convst_n_o(convst_n),
    .cs_n_o(cs_n), .rd_n_o(rd_n), .byte_sel_o(byte_sel), .bus_sel_o(bus_sel),
    .sample_o(sample), .done_o(done), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [1:0] exp_sel(input logic [1:0] m, input int i);
    if (m == 2'd1) return (i == 1) ? 2'b01 : 2'b00;
    if (m == 2'd2) return (i == 0) ? 2'b00 : ((i == 1) ? 2'b10 : 2'b11);
    return 2'b00;
  endfunction

  function automatic logic [17:0] bus_img(input logic [17:0] w, input logic b, input logic s);
    case ({b, s})
      2'b00:   return w;
      2'b10:   return {w[9:2], 10'h3FF};
      2'b01:   return {14'h3FFF, w[1:0], 2'b11};
      default: return {6'h3F, w[1:0], 10'h3FF};
    endcase
  endfunction

  // monitor and converter model, evaluated mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      logic [1:0] sel;
      bit actv, fell_now;
      sel = {byte_sel, bus_sel};
      actv = !rd_n || (sel != prev_sel);
      fell_now = 0;
      if (sel != prev_sel) sel_age = 0; else sel_age++;
      if (!convst_n && prev_conv) begin
        convst_falls++;
        chk(quiet_run >= PRE_QUIET, "R8 pre-window", quiet_run, PRE_QUIET);
        chk(!cs_n, "R2 cs at convst", cs_n, 0);
        post_open = 1; post_run = 0; reads_seen = 0; rd_idx = 0;
        busy_adc = 1'b1; bcnt = conv_cyc; conv_open = 1; conv_low_run = 0; fell_now = 1;
      end
      if (!convst_n) conv_low_run++;
      if (convst_n && !prev_conv) chk(conv_low_run == CONV_LOW, "R2 width", conv_low_run, CONV_LOW);
      if (post_open) begin
        if (actv) begin
          chk(post_run >= POST_QUIET, "R8 post-window", post_run, POST_QUIET);
          post_open = 0;
        end else post_run++;
      end
      if (!rd_n && prev_rd) begin
        rd_total++;
        chk(!cs_n, "R9 cs at read", cs_n, 0);
        chk(sel_age >= SETUP_CYC, "R9 setup", sel_age, SETUP_CYC);
        chk(!conv_open, "R3 read before busy fall", conv_open, 0);
        if (convst_falls > 0)
          chk(sel == exp_sel(mode, rd_idx), (mode == 2'd2) ? "R6 selects" : "R5 selects", sel, exp_sel(mode, rd_idx));
        rd_idx++; reads_seen++;
      end
      if (actv) quiet_run = 0; else quiet_run++;
      if (busy_adc && !fell_now) begin
        if (bcnt <= 1) begin busy_adc = 1'b0; conv_open = 0; end
        else bcnt--;
      end
      if (!cs_n && !rd_n) begin
        rd_lo_cnt++;
        data = (rd_lo_cnt >= 2) ? bus_img(adc_word, byte_sel, bus_sel) : 18'h2AAAA;
      end else begin
        rd_lo_cnt = 0;
        data = 18'h3FFFF;
      end
      prev_rd = rd_n; prev_conv = convst_n; prev_sel = sel;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int n = 0; n < 5000 && !seen; n++) begin
      @(negedge clk); #1;
      if (done) seen = 1;
    end
  endtask

  task automatic run_vec(input vec_t v);
    bit seen;
    string tag;
    @(negedge clk);
    mode = v.mode; skip = v.skip; conv_cyc = v.conv; adc_word = v.word; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(seen);
    tag = (v.mode == 2'd0) ? "R4" : (v.skip ? "R7" : ((v.mode == 2'd1) ? "R5" : "R6"));
    chk(seen, "R11 done seen", seen, 1);
    chk(sample == v.expv, tag, sample, v.expv);
    chk(reads_seen == int'(v.nrd), tag, reads_seen, v.nrd);
    @(negedge clk); #1;
    chk(!done, "R11 pulse", done, 0);
    chk(sample == v.expv, "R11 hold", sample, v.expv);
  endtask

  initial begin
    bit seen;
    int f0;
    repeat (3) @(negedge clk);
    #1;
    chk(convst_n && rd_n, "R1 reset strobes", {convst_n, rd_n}, 2'b11);
    chk(!done && sample == 18'd0, "R11 reset outputs", sample, 0);
    chk(busy, "R1 busy in reset", busy, 1);
    @(negedge clk); rst_n = 1'b1;
    for (int n = 0; n < 500 && busy; n++) @(negedge clk);
    #1;
    chk(!busy, "R1 init ends", busy, 0);
    chk(rd_total == 3, "R1 init reads", rd_total, 3);
    chk(convst_falls == 0, "R1 no convst in init", convst_falls, 0);

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

    // R10: request inside the blackout right after a done
    @(negedge clk);
    mode = 2'd0; conv_cyc = 8'd5; adc_word = 18'h0F0F0;
    f0 = convst_falls; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done(seen);
    chk(seen && convst_falls == f0 + 1, "R10 held request", convst_falls, f0 + 1);
    chk(sample == 18'h0F0F0, "R10 sample", sample, 18'h0F0F0);

    // R12: request during an active conversion is dropped
    @(negedge clk);
    adc_word = 18'h12345; conv_cyc = 8'd20; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int n = 0; n < 200 && convst_n; n++) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done(seen);
    f0 = convst_falls;
    repeat (80) @(negedge clk);
    #1;
    chk(convst_falls == f0, "R12 dropped request", convst_falls, f0);
    chk(sample == 18'h12345, "R12 sample", sample, 18'h12345);

    // R13: periodic tick
    @(negedge clk);
    mode = 2'd2; skip = 1'b0; adc_word = 18'h2C3D1; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    wait_done(seen);
    chk(seen, "R13 tick done", seen, 1);
    chk(sample == 18'h2C3D1, "R13 sample", sample, 18'h2C3D1);

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule